// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block keeps the instruction address of a single-cycle 32-bit processor and works out the address of the following instruction on every clock. The main decoder gives it a 2-bit target code. The datapath gives it the current instruction's 16-bit branch displacement and 26-bit jump field, a general register value for register-indirect jumps, and the result of the branch compare. All four possible targets feed one 4-way selector. A single register holds the address, and it loads the selected value on each rising edge.

The incremented address (current address plus four) is also brought out directly. A link instruction can then write it to the register file in the same cycle.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `pc` becomes 0x00003000 after that edge. Reset takes priority over every other input, including `tgt_sel` = 11.
- R2: `pc_inc` always equals `pc` + 4, wrapping modulo 2^32 (0xFFFFFFFC gives 0x00000000).
- R3: With `tgt_sel` = 00, the next `pc` is `pc` + 4.
- R4: With `tgt_sel` = 01 and `cmp_ok` = 1, the next `pc` is `pc` + 4 plus the sign-extended `br_disp` shifted left by two. A displacement with bit 15 set moves the address backward.
- R5: With `tgt_sel` = 01 and `cmp_ok` = 0, the next `pc` is `pc` + 4.
- R6: With `tgt_sel` = 10, the next `pc` is bits [31:28] of `pc` + 4, followed by `jmp_idx`, followed by two zero bits.
- R7: With `tgt_sel` = 11, the next `pc` is the whole 32-bit `reg_tgt`, unchanged, whatever register it was read from.
- R8: `cmp_ok` has no effect when `tgt_sel` is not 01.
- R9: `pc` changes only at a rising edge of `clk`. The next-address value depends only on the current `pc` and the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `pc` loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_disp | input | 16 | Branch displacement field of the current instruction |
| jmp_idx | input | 26 | Jump index field of the current instruction |
| reg_tgt | input | 32 | Register operand used for register-indirect jumps |
| cmp_ok | input | 1 | Branch condition result; 1 means the branch is taken |
| tgt_sel | input | 2 | Target code: 00 increment, 01 branch, 10 jump, 11 register |
| pc | output | 32 | Current instruction address |
| pc_inc | output | 32 | Current address plus four, used for link writes |

## Verification
The assertions assume that `tgt_sel`, `cmp_ok` and the field inputs are known and steady around each rising edge. They also assume that reset is held for at least one edge before the checks that use `$past` start. To stay within this, the stimulus changes inputs only on the falling edge and holds reset from time zero. The displacements, indices and register values are chosen to drive the address across the 32-bit wrap and into the upper 4-bit region. They also produce an unaligned register target, and each of those cases still has to be predicted exactly.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter logic [31:0] RESET_VEC = 32'h0000_3000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] br_disp,
  input  logic [25:0] jmp_idx,
  input  logic [31:0] reg_tgt,
  input  logic        cmp_ok,
  input  logic [1:0]  tgt_sel,
  output logic [31:0] pc,
  output logic [31:0] pc_inc
);

  logic [31:0] disp_ext;
  logic [31:0] cand [4];
  logic [31:0] pc_nxt;

  assign pc_inc   = pc + 32'd4;
  assign disp_ext = {{14{br_disp[15]}}, br_disp, 2'b00};

  assign cand[0] = pc_inc;
  assign cand[1] = cmp_ok ? (pc_inc + disp_ext) : pc_inc;
  assign cand[2] = {pc_inc[31:28], jmp_idx, 2'b00};
  assign cand[3] = reg_tgt;

  assign pc_nxt = cand[tgt_sel];

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_VEC;
    else     pc <= pc_nxt;
  end

  // R1
  reset_vec_chk: assert property (@(posedge clk) rst |=> pc == RESET_VEC);

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_sel == 2'b00 |=> pc == $past(pc) + 32'd4);

  // R5
  br_fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_sel == 2'b01 && !cmp_ok) |=> pc == $past(pc) + 32'd4);

  // R6
  jmp_field_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_sel == 2'b10 |=> (pc[27:0] == {$past(jmp_idx), 2'b00}) &&
                         (pc[31:28] == $past(pc_inc[31:28])));

  // R7
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_sel == 2'b11 |=> pc == $past(reg_tgt));

endmodule

// File: tb/sim_next_pc_unit.sv
module sim_next_pc_unit;
  localparam int CLK_P = 10;
  localparam int NV = 13;

  // {sel[2], taken[1], disp[16], idx[26], reg[32], expected pc[32]}
  localparam logic [108:0] VEC [NV] = '{
    {2'd0, 1'b0, 16'h0000, 26'h0000000, 32'h0,         32'h0000_3004}, // R3
    {2'd1, 1'b1, 16'h0010, 26'h0000000, 32'h0,         32'h0000_3048}, // R4
    {2'd1, 1'b0, 16'h0010, 26'h0000000, 32'h0,         32'h0000_304C}, // R5
    {2'd1, 1'b1, 16'hFFFF, 26'h0000000, 32'h0,         32'h0000_304C}, // R4 backward
    {2'd2, 1'b0, 16'h0000, 26'h0000100, 32'h0,         32'h0000_0400}, // R6
    {2'd3, 1'b0, 16'h0000, 26'h0000000, 32'h0000_3100, 32'h0000_3100}, // R7
    {2'd0, 1'b1, 16'h7FFF, 26'h0000000, 32'h0,         32'h0000_3104}, // R8
    {2'd1, 1'b1, 16'h8000, 26'h0000000, 32'h0,         32'hFFFE_3108}, // R4 most negative
    {2'd2, 1'b0, 16'h0000, 26'h3FFFFFF, 32'h0,         32'hFFFF_FFFC}, // R6 upper bits
    {2'd0, 1'b0, 16'h0000, 26'h0000000, 32'h0,         32'h0000_0000}, // R2 wrap
    {2'd3, 1'b1, 16'h1234, 26'h0000000, 32'hDEAD_BEE1, 32'hDEAD_BEE1}, // R7 R8
    {2'd2, 1'b1, 16'h0040, 26'h0000004, 32'h0,         32'hD000_0010}, // R6 R8
    {2'd3, 1'b0, 16'h0000, 26'h0000000, 32'h0040_0000, 32'h0040_0000}  // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] br_disp = '0;
  logic [25:0] jmp_idx = '0;
  logic [31:0] reg_tgt = '0;
  logic        cmp_ok = 1'b0;
  logic [1:0]  tgt_sel = 2'b00;
  logic [31:0] pc, pc_inc;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  next_pc_unit u0 (
    .clk(clk), .rst(rst), .br_disp(br_disp), .jmp_idx(jmp_idx),
    .reg_tgt(reg_tgt), .cmp_ok(cmp_ok), .tgt_sel(tgt_sel),
    .pc(pc), .pc_inc(pc_inc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", pc, 32'h0000_3000);
    check("R2 reset pc_inc", pc_inc, 32'h0000_3004);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {tgt_sel, cmp_ok, br_disp, jmp_idx, reg_tgt} = VEC[i][108:32];
      #1;
      check("R9 no change before edge", pc, i == 0 ? 32'h0000_3000 : VEC[i-1][31:0]);
      @(posedge clk);
      #1;
      check($sformatf("R3-7 vector %0d pc", i), pc, VEC[i][31:0]);
      check($sformatf("R2 vector %0d pc_inc", i), pc_inc, VEC[i][31:0] + 32'd4);
      @(negedge clk);
    end

    // R1: reset wins over a register jump
    tgt_sel = 2'b11; reg_tgt = 32'h1111_2220; rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset over sel=11", pc, 32'h0000_3000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R7 jump after reset", pc, 32'h1111_2220);
    @(negedge clk);

    // R5: not-taken branch with large displacement
    tgt_sel = 2'b01; cmp_ok = 1'b0; br_disp = 16'h8000;
    @(posedge clk); #1;
    check("R5 not taken", pc, 32'h1111_2224);
    @(negedge clk);

    finish_run();
  end
endmodule